// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a word-organised static memory whose control interface works like an asynchronous SRAM with separate byte-lane selects. A requester presents an address, a write-data word, an active-low chip select, an active-low write strobe, an active-low output enable and one active-low select per 8-bit lane. The core decodes four operating modes: deselected, output disabled, read and write. Each lane is masked on its own, for reads and for writes alike.

Pads that drive in both directions are replaced by a separate read-data bus and a per-lane drive vector. A lane whose drive bit is 0 stands for a high-impedance lane. Every control and data input is sampled on a single clock, so the core can be synthesized. The storage is split into one inferable block-RAM bank per lane. The default build is small. The full 131,072-word by 16-bit configuration uses `ADDR_W = 17` with `DATA_W = 16`.

Top module: `bytelane_sram`

## Requirements
- R1: The core stores 2**ADDR_W words of DATA_W bits (131,072 x 16 when ADDR_W=17). Lane i covers bits 8i+7:8i, so with 16 bits byte_sel_n[0] gates bits 7:0 and byte_sel_n[1] gates bits 15:8.
- R2: With chip_sel_n high, lane_drive is all zero and nothing is written, whatever the other controls are.
- R3: With chip_sel_n low, wr_n high and rd_en_n high, lane_drive is all zero and nothing is written.
- R4: With chip_sel_n low and every byte_sel_n bit high, lane_drive is all zero and no lane is written, whatever the other controls are.
- R5: A read (chip_sel_n low, wr_n high, rd_en_n low) sets lane_drive to the inverse of byte_sel_n. Each driven lane of rdata carries that lane's stored byte at the address.
- R6: A write takes place whenever chip_sel_n and wr_n are both low, whatever rd_en_n is. Only lanes whose byte_sel_n bit is low are updated, and the other lanes keep their previous contents.
- R7: During a write, lane_drive is all zero.
- R8: Inputs present before clock edge k are decoded at edge k. Their effect on lane_drive and rdata is visible after edge k+1. A write sampled at edge k is seen by a read sampled at edge k+1 or later.
- R9: While rst is high, and on the first cycle after it falls, lane_drive is all zero. Memory contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low output enable |
| byte_sel_n | input | DATA_W/8 | Active-low lane selects, bit i gates bits 8i+7:8i |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, meaningful only on driven lanes |
| lane_drive | output | DATA_W/8 | Per-lane drive enable; 0 means the lane is high-impedance |

## Verification
The embedded properties check the drive vector against the sampled controls on every cycle. They cover silence when deselected, when output is disabled, when all lanes are unselected and during writes, and they check that a read drives exactly the selected lanes. Whether the data on a driven lane is correct cannot be seen by a property. Nor can it show that an unselected lane survives a write, that a write with output enable low still lands, or that an attempted write with no lanes selected leaves memory untouched. Those are shown only by the bench's scenarios, which compare read-backs against a byte-masked memory model.

// File: rtl/bytelane_sram_pkg.sv
package bytelane_sram_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_QUIET = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;

  localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/bytelane_sram_ctrl.sv
module bytelane_sram_ctrl
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [LANES-1:0]  sel_n_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_n_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic [LANES-1:0]  sel_n_q,
  output sram_mode_e        mode_o,
  output logic [LANES-1:0]  wr_lanes_o,
  output logic [LANES-1:0]  rd_lanes_o
);

  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    if (rst) begin
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      sel_n_q <= '1;
    end else begin
      cs_n_q  <= cs_n_i;
      we_n_q  <= we_n_i;
      oe_n_q  <= oe_n_i;
      sel_n_q <= sel_n_i;
    end
  end

  // Mode decode: chip select dominates, then the lane selects, then the write strobe, then the output enable.
  always_comb begin
    if (cs_n_q || (&sel_n_q))
      mode_o = MODE_IDLE;
    else if (!we_n_q)
      mode_o = MODE_WRITE;
    else if (!oe_n_q)
      mode_o = MODE_READ;
    else
      mode_o = MODE_QUIET;
  end

  always_comb begin
    wr_lanes_o = (mode_o == MODE_WRITE) ? ~sel_n_q : '0;
    rd_lanes_o = (mode_o == MODE_READ)  ? ~sel_n_q : '0;
  end

  AST_LANES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !((|wr_lanes_o) && (|rd_lanes_o))); // R7

endmodule

// File: rtl/bytelane_sram_bank.sv
module bytelane_sram_bank #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wd,
  output logic [WIDTH-1:0]  rd
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[addr] <= wd;
    rd <= store[addr];
  end

endmodule

// File: rtl/bytelane_sram_outreg.sv
module bytelane_sram_outreg #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rd_lanes,
  output logic [LANES-1:0] drive
);

  always_ff @(posedge clk) begin
    if (rst)
      drive <= '0;
    else
      drive <= rd_lanes;
  end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bytelane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          chip_sel_n,
  input  logic                          wr_n,
  input  logic                          rd_en_n,
  input  logic [DATA_W/LANE_BITS-1:0]   byte_sel_n,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [DATA_W/LANE_BITS-1:0]   lane_drive
);

  localparam int unsigned LANES = DATA_W / LANE_BITS;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cs_n_q, we_n_q, oe_n_q;
  logic [LANES-1:0]  sel_n_q;
  logic [LANES-1:0]  wr_lanes, rd_lanes;
  sram_mode_e        mode;

  always_ff @(posedge clk) wdata_q <= wdata;

  bytelane_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst),
    .addr_i(addr), .cs_n_i(chip_sel_n), .we_n_i(wr_n), .oe_n_i(rd_en_n), .sel_n_i(byte_sel_n),
    .addr_q(addr_q), .cs_n_q(cs_n_q), .we_n_q(we_n_q), .oe_n_q(oe_n_q), .sel_n_q(sel_n_q),
    .mode_o(mode), .wr_lanes_o(wr_lanes), .rd_lanes_o(rd_lanes)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bytelane_sram_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_BITS)) u_bank (
      .clk(clk),
      .we(wr_lanes[g]),
      .addr(addr_q),
      .wd(wdata_q[g*LANE_BITS +: LANE_BITS]),
      .rd(rdata[g*LANE_BITS +: LANE_BITS])
    );
  end

  bytelane_sram_outreg #(.LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .rd_lanes(rd_lanes), .drive(lane_drive)
  );

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |=> (lane_drive == '0)); // R2
  AST_OUTPUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && we_n_q && oe_n_q) |=> (lane_drive == '0)); // R3
  AST_NO_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&sel_n_q) |=> (lane_drive == '0)); // R4
  AST_READ_LANES: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && we_n_q && !oe_n_q) |=> (lane_drive == ~$past(sel_n_q))); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && !we_n_q) |=> (lane_drive == '0)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (lane_drive == '0)); // R9
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE) |-> (!cs_n_q && !we_n_q)); // R6

endmodule

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;

  localparam int unsigned AW = 11;
  localparam int unsigned DW = 16;
  localparam int unsigned NL = DW / 8;

  typedef struct {
    logic [NL-1:0] drive;
    logic [DW-1:0] data;
    logic [NL-1:0] known;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          chip_sel_n = 1'b1, wr_n = 1'b1, rd_en_n = 1'b1;
  logic [NL-1:0] byte_sel_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NL-1:0] lane_drive;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t q[$];
  logic [7:0] model [int];

  always #10 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .chip_sel_n(chip_sel_n), .wr_n(wr_n),
    .rd_en_n(rd_en_n), .byte_sel_n(byte_sel_n), .wdata(wdata),
    .rdata(rdata), .lane_drive(lane_drive)
  );

  task automatic op(input logic [AW-1:0] a, input logic cs, input logic we, input logic oe,
                    input logic [NL-1:0] sel, input logic [DW-1:0] d, input string req);
    exp_t e;
    @(negedge clk);
    addr = a; chip_sel_n = cs; wr_n = we; rd_en_n = oe; byte_sel_n = sel; wdata = d;
    e.drive = '0; e.data = '0; e.known = '0; e.req = req;
    if (!cs && !(&sel)) begin
      if (!we) begin
        for (int i = 0; i < NL; i++)
          if (!sel[i]) model[int'(a) * NL + i] = d[i*8 +: 8];
      end else if (!oe) begin
        e.drive = ~sel;
        for (int i = 0; i < NL; i++)
          if (model.exists(int'(a) * NL + i)) begin
            e.known[i] = 1'b1;
            e.data[i*8 +: 8] = model[int'(a) * NL + i];
          end
      end
    end
    q.push_back(e);
  endtask

  task automatic idle();
    op('0, 1'b1, 1'b1, 1'b1, '1, '0, "R2");
  endtask

  // Monitor: each result shows after the second rising edge following its drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() >= 2) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (lane_drive !== e.drive) begin
          bad++;
          $display("FAIL %s lane_drive actual=%b expected=%b", e.req, lane_drive, e.drive);
        end else begin
          for (int i = 0; i < NL; i++)
            if (e.drive[i] && e.known[i] && rdata[i*8 +: 8] !== e.data[i*8 +: 8]) begin
              bad++;
              $display("FAIL %s lane %0d data actual=%h expected=%h", e.req, i,
                       rdata[i*8 +: 8], e.data[i*8 +: 8]);
            end
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset dominates a read-shaped input pattern
    @(negedge clk);
    chip_sel_n = 1'b0; wr_n = 1'b1; rd_en_n = 1'b0; byte_sel_n = '0;
    repeat (4) @(negedge clk);
    total++;
    if (lane_drive !== '0) begin
      bad++;
      $display("FAIL R9 reset lane_drive actual=%b expected=%b", lane_drive, 2'b00);
    end
    chip_sel_n = 1'b1; rd_en_n = 1'b1; byte_sel_n = '1;
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (lane_drive !== '0) begin
      bad++;
      $display("FAIL R9 post-reset lane_drive actual=%b expected=%b", lane_drive, 2'b00);
    end

    // R1 R6: full-word writes, including the top address
    op(11'h000, 0, 0, 1, 2'b00, 16'hA5C3, "R6");
    op(11'h7FF, 0, 0, 1, 2'b00, 16'h1234, "R1");
    op(11'h155, 0, 0, 0, 2'b00, 16'hBEEF, "R6");   // write with output enable low
    // R5 R8: back-to-back read after write
    op(11'h155, 0, 1, 0, 2'b00, 16'h0000, "R8");
    op(11'h000, 0, 1, 0, 2'b00, 16'h0000, "R5");
    op(11'h7FF, 0, 1, 0, 2'b00, 16'h0000, "R1");
    // R5: single-lane reads
    op(11'h000, 0, 1, 0, 2'b10, 16'h0000, "R5");
    op(11'h000, 0, 1, 0, 2'b01, 16'h0000, "R5");
    // R6: lower-only then upper-only writes keep the other lane
    op(11'h000, 0, 0, 1, 2'b10, 16'hFF11, "R6");
    op(11'h000, 0, 1, 0, 2'b00, 16'h0000, "R6");
    op(11'h7FF, 0, 0, 0, 2'b01, 16'h9900, "R6");
    op(11'h7FF, 0, 1, 0, 2'b00, 16'h0000, "R6");
    // R4: write attempt with no lane selected, then read-back
    op(11'h155, 0, 0, 1, 2'b11, 16'h0000, "R4");
    op(11'h155, 0, 1, 0, 2'b11, 16'h0000, "R4");
    op(11'h155, 0, 1, 0, 2'b00, 16'h0000, "R4");
    // R2: deselected with write and read shaped controls
    op(11'h155, 1, 0, 0, 2'b00, 16'h7777, "R2");
    op(11'h155, 1, 1, 0, 2'b00, 16'h0000, "R2");
    op(11'h155, 0, 1, 0, 2'b00, 16'h0000, "R2");
    // R3: output disabled, with write data present on the bus
    op(11'h000, 0, 1, 1, 2'b00, 16'h4444, "R3");
    op(11'h000, 0, 1, 0, 2'b00, 16'h0000, "R3");
    // R7: consecutive writes keep the outputs quiet
    op(11'h0AA, 0, 0, 0, 2'b00, 16'h0F0F, "R7");
    op(11'h0AB, 0, 0, 0, 2'b01, 16'hF0F0, "R7");
    op(11'h0AA, 0, 1, 0, 2'b00, 16'h0000, "R8");
    op(11'h0AB, 0, 1, 0, 2'b01, 16'h0000, "R8");
    // sweep of patterned words
    for (int k = 0; k < 16; k++)
      op(AW'(k * 37), 0, 0, 1, 2'(k % 3), 16'(k * 16'h1357), "R6");
    for (int k = 0; k < 16; k++)
      op(AW'(k * 37), 0, 1, 0, 2'b00, 16'h0000, "R5");
    repeat (3) idle();
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule